// File: doc/BRIEF.md
# Dual-Buffer Transmit Control Unit

This block is the transmit half of a small memory-mapped Ethernet controller. Software fills one of two packet buffers through a 32-bit word bus. It then programs that buffer's byte length and writes its control word. One control word carries two commands. The start bit with the program bit clear streams the buffer out as a frame. The start bit with the program bit set copies the first six buffer bytes into the station address register instead.

Frames leave on a byte stream with valid, last and ready signals. Preamble and FCS are added further down the path. The start and program bits double as busy flags, and the hardware clears them when the command ends. A per-buffer interrupt enable and one global enable together decide whether completion produces a one-cycle interrupt pulse.

Top module: `dual_txbuf_unit`

## Requirements
- R1: After synchronous reset, every control word, both length registers, the global enable register and `station_addr` read as zero, and `tx_valid` and `irq` are low.
- R2: `bus_rdata` returns the addressed word one cycle after the address is presented. Word address bit 9 selects the buffer. Within each half, word 0x1FD is the length register and word 0x1FF is the control word. Word 0x1FE of half 0 is the global enable, and word 0x1FE of half 1 reads as zero. The length register keeps bits [10:0] of the written word, and its upper bits read as zero. All other words are buffer storage and read back as written.
- R3: A control write with bit 0 = 1 and bit 1 = 0 sends a frame of exactly `length` bytes. Byte k comes from bits [8*(k mod 4)+7 : 8*(k mod 4)] of buffer word k/4, so bytes leave lowest address first. `tx_last` is high on the final byte only. Data, valid and last hold while `tx_ready` is low.
- R4: A control write with bit 0 = 1 and bit 1 = 1 sends no frame. It sets `station_addr[8k+7:8k]` to buffer byte k for k = 0..5.
- R5: Control bits 0 and 1 read back as written while the command is in progress. When the command completes, both clear, and every other control bit keeps its written value.
- R6: A control write to a buffer whose bit 0 is set is discarded in full, and no command starts from it.
- R7: A buffer armed while the other buffer is busy is served directly after it, with no further bus action. When both are pending at the same time, buffer 0 goes first.
- R8: Completion of either command raises `irq` for exactly one cycle, if and only if that buffer's control bit 3 is set and bit 31 of the global enable is set.
- R9: A send command with length zero completes without any byte on the stream. It still raises `irq` under the R8 conditions.
- R10: A control write with bit 0 = 0 to an idle buffer stores the word unchanged and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Word write strobe |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| irq | output | 1 | One-cycle completion interrupt |
| station_addr | output | 48 | Station MAC address, byte 0 in bits [7:0] |

## Verification
A table of send commands varies the buffer, the length and the interrupt bit. The lengths are 1, 2, 4, 5, 8 and 13 bytes. Together they separate a correct byte-lane order and word-crossing fetch from an off-by-one in the count or in the `tx_last` placement, and buffer-1 addressing from buffer 0. Every third cycle `tx_ready` drops, which exposes any byte that is lost or duplicated under back-pressure. Directed cases then separate the program command from a send. They also cover a command discarded while busy against a queued command on the other buffer, a zero-length send, interrupt gating by each enable, and a control write with the start bit clear.

// File: rtl/dtx_pkg.sv
`timescale 1ns/1ps
package dtx_pkg;
  localparam int CTL_START = 0;
  localparam int CTL_PROG  = 1;
  localparam int CTL_IEN   = 3;
  localparam int GIE_BIT   = 31;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_PRIME, ST_SEND,
    ST_MWAIT0, ST_MCAP0, ST_MWAIT1, ST_MCAP1, ST_DONE
  } eng_state_t;
endpackage

// File: rtl/dtx_buf_ram.sv
`timescale 1ns/1ps
module dtx_buf_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/dtx_engine.sv
`timescale 1ns/1ps
module dtx_engine
  import dtx_pkg::*;
#(
  parameter int BUF_AW = 9,
  parameter int LEN_W  = BUF_AW + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       arm,
  input  logic [1:0]       prog,
  input  logic [1:0]       ien,
  input  logic             gie_on,
  input  logic [LEN_W-1:0] len0,
  input  logic [LEN_W-1:0] len1,
  input  logic [31:0]      ram_q,
  output logic [BUF_AW:0]  ram_addr,
  output logic [1:0]       done,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  output logic             tx_last,
  output logic             irq,
  output logic [47:0]      station_addr
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  eng_state_t       st;
  logic             sel;
  logic [LEN_W-1:0] bcnt;
  logic [LEN_W-1:0] blen;
  logic [31:0]      mac_lo;

  logic             pick;
  logic [LEN_W-1:0] pick_len;
  logic [LEN_W-1:0] nxt_cnt;
  logic [1:0]       nxt_lane;

  assign pick     = ~arm[0];
  assign pick_len = pick ? len1 : len0;
  assign nxt_cnt  = bcnt + ONE;
  assign nxt_lane = bcnt[1:0] + 2'd1;
  assign ram_addr = {sel, bcnt[LEN_W-1:2]};
  assign done     = (st == ST_DONE) ? (sel ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      sel          <= 1'b0;
      bcnt         <= '0;
      blen         <= '0;
      mac_lo       <= '0;
      station_addr <= '0;
      tx_data      <= '0;
      tx_valid     <= 1'b0;
      tx_last      <= 1'b0;
      irq          <= 1'b0;
    end else begin
      irq <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (|arm) begin
            sel  <= pick;
            bcnt <= '0;
            blen <= pick_len;
            if (prog[pick])          st <= ST_MWAIT0;
            else if (pick_len == '0) st <= ST_DONE;
            else                     st <= ST_FETCH;
          end
        end
        ST_FETCH: st <= ST_PRIME;
        ST_PRIME: begin
          tx_data  <= ram_q[{bcnt[1:0], 3'b000} +: 8];
          tx_valid <= 1'b1;
          tx_last  <= (bcnt == blen - ONE);
          st       <= ST_SEND;
        end
        ST_SEND: begin
          if (tx_ready) begin
            if (tx_last) begin
              tx_valid <= 1'b0;
              tx_last  <= 1'b0;
              st       <= ST_DONE;
            end else begin
              bcnt <= nxt_cnt;
              if (bcnt[1:0] == 2'b11) begin
                tx_valid <= 1'b0;
                st       <= ST_FETCH;
              end else begin
                tx_data <= ram_q[{nxt_lane, 3'b000} +: 8];
                tx_last <= (nxt_cnt == blen - ONE);
              end
            end
          end
        end
        ST_MWAIT0: st <= ST_MCAP0;
        ST_MCAP0: begin
          mac_lo <= ram_q;
          bcnt   <= LEN_W'(4);
          st     <= ST_MWAIT1;
        end
        ST_MWAIT1: st <= ST_MCAP1;
        ST_MCAP1: begin
          station_addr <= {ram_q[15:0], mac_lo};
          st           <= ST_DONE;
        end
        ST_DONE: begin
          irq <= ien[sel] & gie_on;
          st  <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_txbuf_unit.sv
`timescale 1ns/1ps
module dual_txbuf_unit
  import dtx_pkg::*;
#(
  parameter int BUF_AW = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [BUF_AW:0]   bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              irq,
  output logic [47:0]       station_addr
);
  localparam int LEN_W = BUF_AW + 2;
  localparam logic [BUF_AW-1:0] OFS_LEN = {{(BUF_AW-2){1'b1}}, 2'b01};
  localparam logic [BUF_AW-1:0] OFS_GIE = {{(BUF_AW-2){1'b1}}, 2'b10};
  localparam logic [BUF_AW-1:0] OFS_CTL = {BUF_AW{1'b1}};

  logic              half;
  logic [BUF_AW-1:0] ofs;
  logic [31:0]       ctrl_r [2];
  logic [LEN_W-1:0]  len_r  [2];
  logic [31:0]       gie_r;
  logic [1:0]        done;
  logic [1:0]        busy_s;
  logic [31:0]       ram_a_q, ram_b_q;
  logic [BUF_AW:0]   ram_b_addr;
  logic              use_reg_q;
  logic [31:0]       reg_rd_q;

  assign half   = bus_addr[BUF_AW];
  assign ofs    = bus_addr[BUF_AW-1:0];
  assign busy_s = {ctrl_r[1][CTL_START], ctrl_r[0][CTL_START]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++) begin
        ctrl_r[b] <= '0;
        len_r[b]  <= '0;
      end
      gie_r <= '0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (done[b]) ctrl_r[b][CTL_PROG:CTL_START] <= 2'b00;
        if (bus_we && half == b[0]) begin
          if (ofs == OFS_LEN) len_r[b] <= bus_wdata[LEN_W-1:0];
          if (ofs == OFS_CTL && !ctrl_r[b][CTL_START]) ctrl_r[b] <= bus_wdata;
        end
      end
      if (bus_we && !half && ofs == OFS_GIE) gie_r <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      use_reg_q <= 1'b0;
      reg_rd_q  <= '0;
    end else begin
      use_reg_q <= (ofs >= OFS_LEN);
      unique case (ofs)
        OFS_LEN: reg_rd_q <= 32'(len_r[half]);
        OFS_GIE: reg_rd_q <= half ? 32'h0 : gie_r;
        OFS_CTL: reg_rd_q <= ctrl_r[half];
        default: reg_rd_q <= '0;
      endcase
    end
  end

  assign bus_rdata = use_reg_q ? reg_rd_q : ram_a_q;

  dtx_buf_ram #(.AW(BUF_AW + 1), .DW(32)) ram_i (
    .clk     (clk),
    .a_we    (bus_we),
    .a_addr  (bus_addr),
    .a_wdata (bus_wdata),
    .a_rdata (ram_a_q),
    .b_addr  (ram_b_addr),
    .b_rdata (ram_b_q)
  );

  dtx_engine #(.BUF_AW(BUF_AW), .LEN_W(LEN_W)) eng_i (
    .clk          (clk),
    .rst          (rst),
    .arm          (busy_s),
    .prog         ({ctrl_r[1][CTL_PROG], ctrl_r[0][CTL_PROG]}),
    .ien          ({ctrl_r[1][CTL_IEN], ctrl_r[0][CTL_IEN]}),
    .gie_on       (gie_r[GIE_BIT]),
    .len0         (len_r[0]),
    .len1         (len_r[1]),
    .ram_q        (ram_b_q),
    .ram_addr     (ram_b_addr),
    .done         (done),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .tx_valid     (tx_valid),
    .tx_last      (tx_last),
    .irq          (irq),
    .station_addr (station_addr)
  );
endmodule

// File: rtl/dual_txbuf_unit_chk.sv
`timescale 1ns/1ps
module dual_txbuf_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        irq,
  input logic        gie_on,
  input logic [1:0]  busy,
  input logic [47:0] station_addr
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) $past(rst) |-> (!tx_valid && !irq));

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst) irq |=> !irq);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst) irq |-> $past(gie_on));

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R5
  busy_while_tx_chk: assert property (@(posedge clk) disable iff (rst) tx_valid |-> (busy != 2'b00));

  // R4
  station_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(station_addr) |-> !tx_valid);
endmodule

bind dual_txbuf_unit dual_txbuf_unit_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_data      (tx_data),
  .tx_last      (tx_last),
  .irq          (irq),
  .gie_on       (gie_r[31]),
  .busy         (busy_s),
  .station_addr (station_addr)
);

// File: tb/dual_txbuf_unit_tb_top.sv
`timescale 1ns/1ps
module dual_txbuf_unit_tb_top;
  localparam int AW = 9;
  localparam logic [AW-1:0] O_LEN = 9'h1FD;
  localparam logic [AW-1:0] O_GIE = 9'h1FE;
  localparam logic [AW-1:0] O_CTL = 9'h1FF;

  typedef struct packed {
    logic        bsel;
    logic [7:0]  len;
    logic [31:0] ctl;
    logic [1:0]  irq_exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 8'd1,  32'h9, 2'd1},
    '{1'b0, 8'd4,  32'h1, 2'd0},
    '{1'b1, 8'd5,  32'h9, 2'd1},
    '{1'b1, 8'd13, 32'h1, 2'd0},
    '{1'b0, 8'd8,  32'h9, 2'd1},
    '{1'b1, 8'd2,  32'h9, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [AW:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, irq;
  logic        tx_ready = 1'b0;
  logic [47:0] station_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0] got_b [64];
  logic       got_l [64];
  int got_n = 0;
  int irq_n = 0;
  bit hold_ready = 1'b0;
  int stall_ph = 0;

  always #2.5 clk = ~clk;

  dual_txbuf_unit #(.BUF_AW(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
    .irq(irq), .station_addr(station_addr)
  );

  always @(negedge clk) begin
    stall_ph = stall_ph + 1;
    tx_ready = !hold_ready && (stall_ph % 3 != 2);
    if (tx_valid && tx_ready) begin
      if (got_n < 64) begin
        got_b[got_n] = tx_data;
        got_l[got_n] = tx_last;
      end
      got_n = got_n + 1;
    end
    if (irq) irq_n = irq_n + 1;
  end

  function automatic logic [7:0] pat(input int b, input int i);
    return 8'((b * 64 + i * 7 + 3) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic fill(input int b, input int len);
    for (int w = 0; w < (len + 3) / 4; w++) begin
      bus_write({b[0], 9'(w)}, {pat(b, 4*w+3), pat(b, 4*w+2), pat(b, 4*w+1), pat(b, 4*w)});
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    got_n = 0;
    irq_n = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic check_frame(input int b, input int len, input int base, input string tag);
    int bad = 0;
    for (int k = 0; k < len; k++) begin
      if (got_b[base+k] !== pat(b, k)) bad++;
      if (got_l[base+k] !== (k == len - 1)) bad++;
    end
    chk(bad == 0, tag, 64'(bad), 64'd0);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk(tx_valid === 1'b0 && irq === 1'b0, "R1 tx_valid/irq", {tx_valid, irq}, 0);
    chk(station_addr === 48'h0, "R1 station", station_addr, 0);
    bus_read({1'b0, O_CTL}, rd); chk(rd === 32'h0, "R1 ctrl0", rd, 0);
    bus_read({1'b1, O_LEN}, rd); chk(rd === 32'h0, "R1 len1", rd, 0);
    bus_read({1'b0, O_GIE}, rd); chk(rd === 32'h0, "R1 gie", rd, 0);

    // R2 register map and storage
    bus_write({1'b1, 9'd5}, 32'hDEADBEEF);
    bus_read({1'b1, 9'd5}, rd); chk(rd === 32'hDEADBEEF, "R2 buffer word", rd, 32'hDEADBEEF);
    bus_write({1'b0, O_LEN}, 32'hFFFFFFFF);
    bus_read({1'b0, O_LEN}, rd); chk(rd === 32'h7FF, "R2 len width", rd, 32'h7FF);
    bus_write({1'b1, O_GIE}, 32'h1234);
    bus_read({1'b1, O_GIE}, rd); chk(rd === 32'h0, "R2 half1 gie slot", rd, 0);
    bus_write({1'b0, O_GIE}, 32'h80000000);
    bus_read({1'b0, O_GIE}, rd); chk(rd === 32'h80000000, "R2 gie", rd, 32'h80000000);

    // R3 R5 R8 table of send commands
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      fill(int'(v.bsel), int'(v.len));
      clear_mon();
      bus_write({v.bsel, O_LEN}, 32'(v.len));
      bus_write({v.bsel, O_CTL}, v.ctl);
      wait_cyc(40 + 4 * int'(v.len));
      chk(got_n == int'(v.len), "R3 byte count", 64'(got_n), 64'(v.len));
      check_frame(int'(v.bsel), int'(v.len), 0, "R3 byte order/last");
      chk(irq_n == int'(v.irq_exp), "R8 irq count", 64'(irq_n), 64'(v.irq_exp));
      bus_read({v.bsel, O_CTL}, rd);
      chk(rd === (v.ctl & ~32'h3), "R5 ctrl after done", rd, v.ctl & ~32'h3);
    end

    // R4 program command
    bus_write({1'b0, 9'd0}, 32'h44332211);
    bus_write({1'b0, 9'd1}, 32'hAAAA6655);
    clear_mon();
    bus_write({1'b0, O_CTL}, 32'hB);
    wait_cyc(30);
    chk(station_addr === 48'h665544332211, "R4 station", station_addr, 48'h665544332211);
    chk(got_n == 0, "R4 no frame", 64'(got_n), 0);
    chk(irq_n == 1, "R8 irq on program", 64'(irq_n), 1);
    bus_read({1'b0, O_CTL}, rd); chk(rd === 32'h8, "R5 ctrl after program", rd, 32'h8);

    // R5 R6 R7 busy, discard, queued buffer
    fill(0, 6);
    fill(1, 3);
    hold_ready = 1'b1;
    clear_mon();
    bus_write({1'b0, O_LEN}, 32'd6);
    bus_write({1'b0, O_CTL}, 32'h1);
    wait_cyc(10);
    bus_read({1'b0, O_CTL}, rd); chk(rd === 32'h1, "R5 busy readback", rd, 32'h1);
    bus_write({1'b0, O_CTL}, 32'h3);
    bus_read({1'b0, O_CTL}, rd); chk(rd === 32'h1, "R6 write discarded", rd, 32'h1);
    bus_write({1'b1, O_LEN}, 32'd3);
    bus_write({1'b1, O_CTL}, 32'h9);
    hold_ready = 1'b0;
    wait_cyc(100);
    chk(got_n == 9, "R7 total bytes", 64'(got_n), 9);
    check_frame(0, 6, 0, "R7 buffer0 first");
    check_frame(1, 3, 6, "R7 buffer1 next");
    chk(station_addr === 48'h665544332211, "R6 no program run", station_addr, 48'h665544332211);
    chk(irq_n == 1, "R8 only buffer1 irq", 64'(irq_n), 1);
    bus_read({1'b0, O_CTL}, rd); chk(rd === 32'h0, "R5 ctrl0 cleared", rd, 0);
    bus_read({1'b1, O_CTL}, rd); chk(rd === 32'h8, "R5 ctrl1 cleared", rd, 32'h8);

    // R9 zero length
    clear_mon();
    bus_write({1'b0, O_LEN}, 32'd0);
    bus_write({1'b0, O_CTL}, 32'h9);
    wait_cyc(20);
    chk(got_n == 0, "R9 no bytes", 64'(got_n), 0);
    chk(irq_n == 1, "R9 irq", 64'(irq_n), 1);
    bus_read({1'b0, O_CTL}, rd); chk(rd === 32'h8, "R9 ctrl done", rd, 32'h8);

    // R8 global enable off
    bus_write({1'b0, O_GIE}, 32'h0);
    fill(0, 2);
    clear_mon();
    bus_write({1'b0, O_LEN}, 32'd2);
    bus_write({1'b0, O_CTL}, 32'h9);
    wait_cyc(30);
    chk(got_n == 2, "R8 frame sent", 64'(got_n), 2);
    chk(irq_n == 0, "R8 gated irq", 64'(irq_n), 0);

    // R10 write with start clear
    clear_mon();
    bus_write({1'b1, O_CTL}, 32'hA);
    wait_cyc(20);
    chk(got_n == 0, "R10 no frame", 64'(got_n), 0);
    bus_read({1'b1, O_CTL}, rd); chk(rd === 32'hA, "R10 stored", rd, 32'hA);
    chk(station_addr === 48'h665544332211, "R10 station kept", station_addr, 48'h665544332211);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule